// File: doc/BRIEF.md
# Sample Autobuffer Engine

This block moves converter samples between the sample data path and on-chip data memory so that the processor does not have to handle every sample. A per-sample tick from the timing unit opens a transfer slot. In that slot the engine reads one word from memory for the transmit side and writes the latest received word to memory for the receive side. It issues these accesses on a simple request/grant memory port.

Each side takes its address from one of eight index registers and adds one of four signed modify registers after every access. The address wraps circularly inside a window that a base and length register set for that index. A 16-bit configuration word turns each side on or off and picks the index and modify registers for it. A side with autobuffering on raises its interrupt only when its buffer wraps. A side with autobuffering off keeps a plain interrupt on every sample. A small write port loads the index, modify, base and length registers.

Top module: `smp_autobuf`

## Requirements
- R1: Configuration bit 0 enables receive autobuffering. In each slot the word that was on `rx_data` at the tick is written to memory at the address held in the selected receive index register.
- R2: Configuration bit 1 enables transmit autobuffering. In each slot one word is read from the address held in the selected transmit index register. It appears on `tx_data`, with `tx_load` high for one cycle, in the cycle after the grant.
- R3: Configuration bits 3:2 select the receive modify register and bits 6:4 the receive index register. Bits 8:7 select the transmit modify register and bits 11:9 the transmit index register.
- R4: Configuration bits 15:12 have no effect on the engine.
- R5: After each access the index becomes I+M, with M read as two's complement. If the length is nonzero, a result at or above base+length is reduced by the length, and a result below the base (negative M) is increased by the length. A length of 0 gives linear addressing with no wrap.
- R6: On an enabled side the interrupt is a one-cycle pulse. It is raised only for the access whose index update wraps, in the cycle after that access is granted.
- R7: On a disabled side the interrupt pulses for one cycle on every accepted tick, in the cycle after the tick. Without ticks no interrupt is raised.
- R8: When both sides are enabled, the transmit read comes before the receive write in the same slot. If both sides name the same index register, the write uses the index already advanced by the read, so the index is updated twice.
- R9: A configuration write does not take effect until the next tick. A slot already in progress completes with the configuration latched at its own tick.
- R10: `mem_req` stays high, and `mem_addr`, `mem_we` and `mem_wdata` stay stable, until `mem_gnt` is seen. A write is the last access of a slot.
- R11: The register write port selects the register with `rf_sel`: 0 = index, 1 = modify, 2 = base, 3 = length. `rf_num` picks the register number, and a rewritten index is used from the next slot.
- R12: A tick that arrives while a slot is still in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Per-sample slot start pulse |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word |
| rf_we | input | 1 | Register file write strobe |
| rf_sel | input | 2 | Register kind: 0 index, 1 modify, 2 base, 3 length |
| rf_num | input | 3 | Register number |
| rf_wdata | input | ADDR_W | Register write value |
| rx_data | input | DATA_W | Latest received sample |
| tx_data | output | DATA_W | Word fetched for the transmit side |
| tx_load | output | 1 | One-cycle strobe, tx_data updated |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_gnt | input | 1 | Memory grant, access completes this cycle |
| mem_rdata | input | DATA_W | Read data, valid with grant |
| rx_irq | output | 1 | Receive interrupt pulse |
| tx_irq | output | 1 | Transmit interrupt pulse |

## Verification
Two things can land on one slot: the transmit read and the receive write, which may also target the same index register. The bench sets both sides to one index register in a two-word window. It then checks that the read is granted first and returns the word stored before the slot, and that the write goes to the address already advanced by the read. It also checks that only the receive side sees the wrap pulse. A second collision occurs when a tick and a configuration rewrite both arrive while a slot is held off by a withheld grant. That slot must finish on its old address, and the tick must be dropped.

// File: rtl/abuf_pkg.sv
package abuf_pkg;
   localparam int CFG_W     = 16;
   localparam int IDX_SEL_W = 3;
   localparam int MOD_SEL_W = 2;

   typedef struct packed {
      logic                 en;
      logic [IDX_SEL_W-1:0] idx;
      logic [MOD_SEL_W-1:0] mdf;
   } side_cfg_t;

   typedef struct packed {
      side_cfg_t tx;
      side_cfg_t rx;
   } eng_cfg_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_TX   = 2'd1,
      ST_RX   = 2'd2
   } slot_st_t;

   typedef enum logic [1:0] {
      RS_INDEX  = 2'd0,
      RS_MODIFY = 2'd1,
      RS_BASE   = 2'd2,
      RS_LENGTH = 2'd3
   } rf_kind_t;
endpackage

// File: rtl/abuf_cfg_decode.sv
module abuf_cfg_decode
   import abuf_pkg::*;
(
   input  logic [CFG_W-1:0] word_i,
   output eng_cfg_t         cfg_o
);
   // upper nibble belongs to an unrelated function and is dropped here
   logic [3:0] unused_hi;
   assign unused_hi = word_i[15:12];

   always_comb begin
      cfg_o.rx.en  = word_i[0];
      cfg_o.tx.en  = word_i[1];
      cfg_o.rx.mdf = word_i[3:2];
      cfg_o.rx.idx = word_i[6:4];
      cfg_o.tx.mdf = word_i[8:7];
      cfg_o.tx.idx = word_i[11:9];
   end
endmodule

// File: rtl/abuf_regfile.sv
module abuf_regfile
   import abuf_pkg::*;
#(
   parameter int NUM_IDX = 8,
   parameter int NUM_MOD = 4,
   parameter int ADDR_W  = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_kind,
   input  logic [IDX_SEL_W-1:0] wr_num,
   input  logic [ADDR_W-1:0]    wr_val,
   input  logic                 upd_en,
   input  logic [IDX_SEL_W-1:0] upd_num,
   input  logic [ADDR_W-1:0]    upd_val,
   output logic [ADDR_W-1:0]    idx_o  [NUM_IDX],
   output logic [ADDR_W-1:0]    base_o [NUM_IDX],
   output logic [ADDR_W-1:0]    len_o  [NUM_IDX],
   output logic [ADDR_W-1:0]    mod_o  [NUM_MOD]
);
   for (genvar i = 0; i < NUM_IDX; i++) begin : g_idx
      logic hit;
      assign hit = wr_en && (wr_num == IDX_SEL_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            idx_o[i]  <= '0;
            base_o[i] <= '0;
            len_o[i]  <= '0;
         end else begin
            // a software write wins over the engine's post-modify
            if (hit && wr_kind == RS_INDEX)
               idx_o[i] <= wr_val;
            else if (upd_en && upd_num == IDX_SEL_W'(i))
               idx_o[i] <= upd_val;
            if (hit && wr_kind == RS_BASE)
               base_o[i] <= wr_val;
            if (hit && wr_kind == RS_LENGTH)
               len_o[i] <= wr_val;
         end
      end
   end

   for (genvar j = 0; j < NUM_MOD; j++) begin : g_mod
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mod_o[j] <= '0;
         else if (wr_en && wr_kind == RS_MODIFY && wr_num == IDX_SEL_W'(j))
            mod_o[j] <= wr_val;
      end
   end
endmodule

// File: rtl/abuf_circ_step.sv
module abuf_circ_step #(
   parameter int ADDR_W = 14
) (
   input  logic [ADDR_W-1:0] cur_i,
   input  logic [ADDR_W-1:0] mdf_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] len_i,
   output logic [ADDR_W-1:0] nxt_o,
   output logic              wrap_o
);
   localparam int EW = ADDR_W + 2;

   logic signed [EW-1:0] s_cur, s_mdf, s_base, s_len, s_end, s_sum, s_res;

   always_comb begin
      s_cur  = signed'({2'b00, cur_i});
      s_mdf  = signed'({{2{mdf_i[ADDR_W-1]}}, mdf_i});
      s_base = signed'({2'b00, base_i});
      s_len  = signed'({2'b00, len_i});
      s_end  = s_base + s_len;
      s_sum  = s_cur + s_mdf;
      s_res  = s_sum;
      wrap_o = 1'b0;
      if (len_i != '0) begin
         if (!mdf_i[ADDR_W-1] && s_sum >= s_end) begin
            s_res  = s_sum - s_len;
            wrap_o = 1'b1;
         end else if (mdf_i[ADDR_W-1] && s_sum < s_base) begin
            s_res  = s_sum + s_len;
            wrap_o = 1'b1;
         end
      end
      nxt_o = s_res[ADDR_W-1:0];
   end
endmodule

// File: rtl/abuf_seq.sv
module abuf_seq
   import abuf_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 cfg_we,
   input  eng_cfg_t             cfg_dec,
   input  logic [DATA_W-1:0]    rx_data,
   input  logic                 mem_gnt,
   input  logic [DATA_W-1:0]    mem_rdata,
   input  logic                 wrapped,
   output logic [IDX_SEL_W-1:0] sel_idx,
   output logic [MOD_SEL_W-1:0] sel_mod,
   output logic                 upd_en,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [DATA_W-1:0]    mem_wdata,
   output logic [DATA_W-1:0]    tx_data,
   output logic                 tx_load,
   output logic                 rx_irq,
   output logic                 tx_irq
);
   slot_st_t          st_q;
   eng_cfg_t          pend_q, act_q;
   logic [DATA_W-1:0] rx_word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else if (cfg_we)
         pend_q <= cfg_dec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         act_q     <= '0;
         rx_word_q <= '0;
         tx_data   <= '0;
         tx_load   <= 1'b0;
         rx_irq    <= 1'b0;
         tx_irq    <= 1'b0;
      end else begin
         tx_load <= 1'b0;
         rx_irq  <= 1'b0;
         tx_irq  <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (tick) begin
               act_q     <= pend_q;
               rx_word_q <= rx_data;
               tx_irq    <= !pend_q.tx.en;
               rx_irq    <= !pend_q.rx.en;
               if (pend_q.tx.en)      st_q <= ST_TX;
               else if (pend_q.rx.en) st_q <= ST_RX;
            end
            ST_TX: if (mem_gnt) begin
               tx_data <= mem_rdata;
               tx_load <= 1'b1;
               tx_irq  <= wrapped;
               st_q    <= act_q.rx.en ? ST_RX : ST_IDLE;
            end
            ST_RX: if (mem_gnt) begin
               rx_irq <= wrapped;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      sel_idx   = (st_q == ST_TX) ? act_q.tx.idx : act_q.rx.idx;
      sel_mod   = (st_q == ST_TX) ? act_q.tx.mdf : act_q.rx.mdf;
      mem_req   = (st_q != ST_IDLE);
      mem_we    = (st_q == ST_RX);
      mem_wdata = rx_word_q;
      upd_en    = mem_req && mem_gnt;
   end
endmodule

// File: rtl/smp_autobuf.sv
module smp_autobuf
   import abuf_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 14,
   parameter int NUM_IDX = 8,
   parameter int NUM_MOD = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cfg_we,
   input  logic [15:0]       cfg_wdata,
   input  logic              rf_we,
   input  logic [1:0]        rf_sel,
   input  logic [2:0]        rf_num,
   input  logic [ADDR_W-1:0] rf_wdata,
   input  logic [DATA_W-1:0] rx_data,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_load,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rx_irq,
   output logic              tx_irq
);
   if (NUM_IDX < 1 || NUM_IDX > (1 << IDX_SEL_W)) begin : g_bad_idx
      $error("NUM_IDX must fit the 3-bit index select field");
   end
   if (NUM_MOD < 1 || NUM_MOD > (1 << MOD_SEL_W)) begin : g_bad_mod
      $error("NUM_MOD must fit the 2-bit modify select field");
   end
   if (ADDR_W < 2 || DATA_W < 1) begin : g_bad_w
      $error("ADDR_W and DATA_W are too small");
   end

   eng_cfg_t             cfg_dec;
   logic [IDX_SEL_W-1:0] sel_idx;
   logic [MOD_SEL_W-1:0] sel_mod;
   logic                 upd_en, wrapped;
   logic [ADDR_W-1:0]    nxt_addr, cur_mdf, cur_base, cur_len;
   logic [ADDR_W-1:0]    idx_arr  [NUM_IDX];
   logic [ADDR_W-1:0]    base_arr [NUM_IDX];
   logic [ADDR_W-1:0]    len_arr  [NUM_IDX];
   logic [ADDR_W-1:0]    mod_arr  [NUM_MOD];

   abuf_cfg_decode u_dec (
      .word_i (cfg_wdata),
      .cfg_o  (cfg_dec)
   );

   abuf_regfile #(
      .NUM_IDX (NUM_IDX),
      .NUM_MOD (NUM_MOD),
      .ADDR_W  (ADDR_W)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rf_we),
      .wr_kind (rf_sel),
      .wr_num  (rf_num),
      .wr_val  (rf_wdata),
      .upd_en  (upd_en),
      .upd_num (sel_idx),
      .upd_val (nxt_addr),
      .idx_o   (idx_arr),
      .base_o  (base_arr),
      .len_o   (len_arr),
      .mod_o   (mod_arr)
   );

   always_comb begin
      mem_addr = '0;
      cur_base = '0;
      cur_len  = '0;
      for (int i = 0; i < NUM_IDX; i++) begin
         if (sel_idx == IDX_SEL_W'(i)) begin
            mem_addr = idx_arr[i];
            cur_base = base_arr[i];
            cur_len  = len_arr[i];
         end
      end
      cur_mdf = '0;
      for (int j = 0; j < NUM_MOD; j++) begin
         if (sel_mod == MOD_SEL_W'(j))
            cur_mdf = mod_arr[j];
      end
   end

   abuf_circ_step #(
      .ADDR_W (ADDR_W)
   ) u_step (
      .cur_i  (mem_addr),
      .mdf_i  (cur_mdf),
      .base_i (cur_base),
      .len_i  (cur_len),
      .nxt_o  (nxt_addr),
      .wrap_o (wrapped)
   );

   abuf_seq #(
      .DATA_W (DATA_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cfg_we    (cfg_we),
      .cfg_dec   (cfg_dec),
      .rx_data   (rx_data),
      .mem_gnt   (mem_gnt),
      .mem_rdata (mem_rdata),
      .wrapped   (wrapped),
      .sel_idx   (sel_idx),
      .sel_mod   (sel_mod),
      .upd_en    (upd_en),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .tx_data   (tx_data),
      .tx_load   (tx_load),
      .rx_irq    (rx_irq),
      .tx_irq    (tx_irq)
   );
endmodule

// File: rtl/abuf_chk.sv
module abuf_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_load,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_gnt,
   input logic              rx_irq,
   input logic              tx_irq
);
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   a_r10_write_last: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_gnt && mem_we |=> !mem_req);

   a_r6_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> !rx_irq);

   a_r6_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> !tx_irq);

   a_r2_load_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> $past(mem_req && mem_gnt && !mem_we));
endmodule

bind smp_autobuf abuf_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_load   (tx_load),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_gnt   (mem_gnt),
   .rx_irq    (rx_irq),
   .tx_irq    (tx_irq)
);

// File: tb/smp_autobuf_tb.sv
`timescale 1ns/1ps
module smp_autobuf_tb;
   localparam int DW = 16;
   localparam int AW = 14;

   logic          clk = 1'b0;
   logic          rst_n, tick, cfg_we, rf_we;
   logic [15:0]   cfg_wdata;
   logic [1:0]    rf_sel;
   logic [2:0]    rf_num;
   logic [AW-1:0] rf_wdata, mem_addr;
   logic [DW-1:0] rx_data, tx_data, mem_wdata, mem_rdata;
   logic          tx_load, mem_req, mem_we, mem_gnt, rx_irq, tx_irq;

   logic          gnt_en, pl_en;
   logic [7:0]    pl_addr;
   logic [DW-1:0] pl_dat;
   logic [DW-1:0] mem [0:255];

   int checks = 0, errors = 0;
   int n_rd, n_wr, n_rxi, n_txi, n_load, ord;
   int rd_addr, wr_addr, wr_dat, ld_dat;

   always #2.5 clk = ~clk;

   smp_autobuf u_dut (
      .clk (clk), .rst_n (rst_n), .tick (tick), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
      .rf_we (rf_we), .rf_sel (rf_sel), .rf_num (rf_num), .rf_wdata (rf_wdata),
      .rx_data (rx_data), .tx_data (tx_data), .tx_load (tx_load), .mem_req (mem_req),
      .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_gnt (mem_gnt),
      .mem_rdata (mem_rdata), .rx_irq (rx_irq), .tx_irq (tx_irq)
   );

   assign mem_gnt   = mem_req & gnt_en;
   assign mem_rdata = mem[mem_addr[7:0]];

   always @(posedge clk) begin
      if (pl_en) mem[pl_addr] <= pl_dat;
      else if (mem_req && mem_gnt && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
   end

   always @(negedge clk) begin
      if (mem_req && mem_gnt) begin
         ord = ord * 10 + (mem_we ? 2 : 1);
         if (mem_we) begin n_wr++; wr_addr = int'(mem_addr); wr_dat = int'(mem_wdata); end
         else begin n_rd++; rd_addr = int'(mem_addr); end
      end
      if (rx_irq) n_rxi++;
      if (tx_irq) n_txi++;
      if (tx_load) begin n_load++; ld_dat = int'(tx_data); end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clr();
      n_rd = 0; n_wr = 0; n_rxi = 0; n_txi = 0; n_load = 0; ord = 0;
      rd_addr = -1; wr_addr = -1; wr_dat = -1; ld_dat = -1;
   endtask

   task automatic wr_reg(logic [1:0] sel, logic [2:0] num, logic [AW-1:0] val);
      rf_we = 1'b1; rf_sel = sel; rf_num = num; rf_wdata = val;
      @(posedge clk); #1 rf_we = 1'b0;
   endtask

   task automatic set_buf(logic [2:0] n, logic [AW-1:0] base, logic [AW-1:0] len, logic [AW-1:0] start);
      wr_reg(2'd2, n, base);
      wr_reg(2'd3, n, len);
      wr_reg(2'd0, n, start);
   endtask

   task automatic wr_cfg(logic [15:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      @(posedge clk); #1 cfg_we = 1'b0;
   endtask

   task automatic preload(logic [7:0] a, logic [DW-1:0] d);
      pl_en = 1'b1; pl_addr = a; pl_dat = d;
      @(posedge clk); #1 pl_en = 1'b0;
   endtask

   task automatic pulse_tick();
      tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
   endtask

   task automatic fire(logic [DW-1:0] rxv);
      clr();
      rx_data = rxv;
      pulse_tick();
      repeat (6) @(posedge clk);
      #1;
   endtask

   task automatic test_reset_and_idle();
      @(negedge clk);
      chk("R7 no irq after reset", int'(rx_irq) + int'(tx_irq), 0);
      chk("R10 no request after reset", int'(mem_req) + int'(tx_load), 0);
      // R9: a configuration write alone starts nothing
      set_buf(3'd2, 14'h10, 14'd4, 14'h10);
      wr_reg(2'd1, 3'd1, 14'd1);
      clr();
      wr_cfg(16'h0025);
      repeat (6) @(posedge clk);
      #1;
      chk("R9 no traffic before tick", n_rd + n_wr + n_rxi + n_txi, 0);
   endtask

   task automatic test_rx_ring();
      // rx enable, rx modify 1, rx index 2
      fire(16'hA001);
      chk("R1 rx write addr", wr_addr, 'h10);
      chk("R1 rx write data", wr_dat, 'hA001);
      chk("R7 tx per-sample irq", n_txi, 1);
      chk("R6 no rx irq before wrap", n_rxi, 0);
      chk("R3 no read with tx disabled", n_rd, 0);
      fire(16'hA002); chk("R5 post-modify", wr_addr, 'h11);
      fire(16'hA003); chk("R5 post-modify", wr_addr, 'h12);
      fire(16'hA004);
      chk("R5 last slot addr", wr_addr, 'h13);
      chk("R6 rx irq on wrap", n_rxi, 1);
      fire(16'hA005);
      chk("R5 wrap to base", wr_addr, 'h10);
      chk("R6 no irq after wrap", n_rxi, 0);
      wr_reg(2'd0, 3'd2, 14'h12);
      fire(16'hA006);
      chk("R11 rewritten index used", wr_addr, 'h12);
   endtask

   task automatic test_tx_ring();
      preload(8'h42, 16'h1111);
      preload(8'h41, 16'h2222);
      preload(8'h40, 16'h3333);
      set_buf(3'd5, 14'h40, 14'd3, 14'h42);
      wr_reg(2'd1, 3'd3, 14'h3FFF);
      // upper nibble set: tx enable, tx modify 3, tx index 5
      wr_cfg(16'hFB82);
      fire(16'h0);
      chk("R4 R3 tx read addr", rd_addr, 'h42);
      chk("R2 tx data", ld_dat, 'h1111);
      chk("R2 one load", n_load, 1);
      chk("R7 rx per-sample irq", n_rxi, 1);
      chk("R4 no write", n_wr, 0);
      fire(16'h0);
      chk("R5 negative modify", rd_addr, 'h41);
      chk("R6 no tx irq", n_txi, 0);
      fire(16'h0);
      chk("R2 tx data base", ld_dat, 'h3333);
      chk("R6 tx irq on wrap", n_txi, 1);
      fire(16'h0);
      chk("R5 wrap below base", rd_addr, 'h42);
   endtask

   task automatic test_shared();
      preload(8'h80, 16'h5555);
      set_buf(3'd0, 14'h80, 14'd2, 14'h80);
      wr_reg(2'd1, 3'd0, 14'd1);
      wr_cfg(16'h0003);
      fire(16'h7777);
      chk("R8 read before write", ord, 12);
      chk("R8 read sees old word", ld_dat, 'h5555);
      chk("R8 write after advance", wr_addr, 'h81);
      chk("R8 rx wraps", n_rxi, 1);
      chk("R8 tx no wrap", n_txi, 0);
      fire(16'h8888);
      chk("R8 second read addr", rd_addr, 'h80);
      chk("R8 second write addr", wr_addr, 'h81);
   endtask

   task automatic test_linear();
      set_buf(3'd3, 14'h0, 14'd0, 14'h20);
      wr_reg(2'd1, 3'd2, 14'd2);
      wr_cfg(16'h0039);
      fire(16'h1);
      chk("R5 linear start", wr_addr, 'h20);
      fire(16'h2);
      fire(16'h3);
      chk("R5 linear no wrap", wr_addr, 'h24);
      chk("R6 no irq linear", n_rxi, 0);
   endtask

   task automatic test_stall();
      set_buf(3'd1, 14'h60, 14'd8, 14'h60);
      wr_cfg(16'h0011);
      gnt_en = 1'b0;
      clr();
      rx_data = 16'hBEEF;
      pulse_tick();
      repeat (3) @(posedge clk);
      #1;
      wr_cfg(16'h0039);
      pulse_tick();
      repeat (3) @(posedge clk);
      #1 gnt_en = 1'b1;
      repeat (6) @(posedge clk);
      #1;
      chk("R12 dropped tick", n_wr, 1);
      chk("R9 old config mid-slot", wr_addr, 'h60);
      chk("R10 held data", wr_dat, 'hBEEF);
      fire(16'hCAFE);
      chk("R9 new config next tick", wr_addr, 'h26);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; tick = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
      rf_we = 1'b0; rf_sel = '0; rf_num = '0; rf_wdata = '0; rx_data = '0;
      gnt_en = 1'b1; pl_en = 1'b0; pl_addr = '0; pl_dat = '0;
      clr();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      test_reset_and_idle();
      test_rx_ring();
      test_tx_ring();
      test_shared();
      test_linear();
      test_stall();
      summary();
      $finish;
   end
endmodule